// File: doc/BRIEF.md
# Transmit Buffer Request and Abort Controller

This block tracks a small set of CAN transmit message buffers. Each buffer has a transmit-request bit, an abort-request bit, a two-bit result code and an abort-status flag. A fixed-length priority scan picks the next buffer to send. The chosen buffer goes to the protocol engine as a one-hot selection. The engine reports frame events back as single-cycle strobes: start of frame, arbitration lost, error, start of CRC delimiter, and successful end.

An abort takes effect at once only for a buffer that is idle, is not selected and is not being scanned. Otherwise the abort waits. For a buffer on the bus it waits until the frame finishes. For a buffer caught in a scan it waits until the scan is over. After an arbitration loss the next scan waits for the CRC delimiter. After an error it starts at once, while the error frame is being sent. Two level interrupts report completed aborts and completed transmissions. Software clears them by writing 00 to the result code.

Top module: `txb_ctrl`

## Requirements
- R1: After reset all request, abort, status, selection and transmitting bits are 0, every result code is 00, the scan is idle and both interrupts are low.
- R2: A scan selects the lowest-index buffer that has a request pending and no abort pending. The selection `sel_oh` and the transmitting vector `xmit_oh` are each at most one-hot.
- R3: A scan keeps `scan_busy` high for exactly NBUF cycles. A scan starts by itself when no buffer is selected or transmitting, no rescan is waiting, and a request is pending.
- R4: An abort request on a buffer that is not transmitting, not selected and not in a scan is taken one cycle after it registers. The result code becomes 01, the request and abort bits clear, and the abort-status bit sets.
- R5: While `scan_busy` is high, a pending abort leaves the request bit set. The abort is taken after the scan ends.
- R6: An abort on a selected or transmitting buffer is held until the frame ends. When `ev_done` arrives, the result code becomes 01, abort-status sets and the request clears.
- R7: When `ev_done` arrives for a transmitting buffer with no abort pending, its result code becomes 10 and its request clears. Code 11 never appears.
- R8: `ev_arb_lost` clears the transmitting vector and the selection. No scan starts until `ev_crc_delim`, which starts one.
- R9: `ev_error` clears the transmitting vector and the selection and starts a scan in the next cycle.
- R10: `irq_abort` equals `abort_ie` AND (some code is 01). `irq_done` equals `done_ie` AND (some code is 10). Writing 00 to a code clears it, along with that buffer's abort-status bit.
- R11: Writes of a non-zero value to a result code are ignored. A transmit-request set is ignored while that buffer's code is non-zero. Buffer i's code sits at `code_out[2i+1:2i]`, and its write data at `code_wdata[2i+1:2i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_set | input | NBUF | Per-buffer pulse that sets the transmit request |
| abort_set | input | NBUF | Per-buffer pulse that sets the abort request (only while a request is pending) |
| code_wr | input | NBUF | Per-buffer result-code write strobe |
| code_wdata | input | 2*NBUF | Result-code write data, two bits per buffer |
| abort_ie | input | 1 | Abort-complete interrupt enable |
| done_ie | input | 1 | Transmit-complete interrupt enable |
| ev_sof | input | 1 | Engine strobe: frame started for the selected buffer |
| ev_arb_lost | input | 1 | Engine strobe: arbitration lost |
| ev_error | input | 1 | Engine strobe: bus error, error frame follows |
| ev_crc_delim | input | 1 | Engine strobe: start of the CRC delimiter |
| ev_done | input | 1 | Engine strobe: frame finished successfully |
| req_bits | output | NBUF | Transmit-request bits |
| abort_bits | output | NBUF | Abort-request bits |
| code_out | output | 2*NBUF | Result codes: 00 none or in progress, 01 aborted, 10 sent |
| abort_sts | output | NBUF | Abort-completed status per buffer |
| sel_oh | output | NBUF | One-hot next buffer to send |
| xmit_oh | output | NBUF | One-hot buffer now on the bus |
| scan_busy | output | 1 | Priority scan in progress |
| irq_abort | output | 1 | Abort-complete interrupt |
| irq_done | output | 1 | Transmit-complete interrupt |

## Verification
The bench first sets two requests in the same cycle. This shows that the lowest index wins, and it times the length of the scan. It then aims an abort at buffers in four states: idle, selected, on the bus, and caught in a running scan. These four separate the immediate path from the two deferred paths. Two transmissions are broken off, one by arbitration loss and one by error. This shows whether the rescan waits for the CRC delimiter or starts at once. Non-zero code writes, request sets on a buffer whose code is still non-zero, and toggled interrupt enables each probe the ignore and gating rules.

// File: rtl/txb_pkg.sv
package txb_pkg;
  typedef enum logic [1:0] {
    RC_NONE    = 2'b00,
    RC_ABORTED = 2'b01,
    RC_SENT    = 2'b10
  } rcode_e;
endpackage

// File: rtl/txb_scan.sv
module txb_scan #(
  parameter int NBUF = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NBUF-1:0] cand,
  output logic            busy,
  output logic            finish,
  output logic [NBUF-1:0] pick
);
  localparam int CW = (NBUF > 1) ? $clog2(NBUF) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBUF - 1);

  function automatic logic [NBUF-1:0] lowest_first(input logic [NBUF-1:0] v);
    logic hit;
    lowest_first = '0;
    hit = 1'b0;
    for (int i = 0; i < NBUF; i++) begin
      if (v[i] && !hit) begin
        lowest_first[i] = 1'b1;
        hit = 1'b1;
      end
    end
  endfunction

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign finish = busy && (cnt == LAST) && !start;
  assign pick   = lowest_first(cand);

  AST_SCAN_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy); // R3
  AST_SCAN_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cnt == '0); // R3
  AST_PICK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick)); // R2
endmodule

// File: rtl/txb_slot.sv
module txb_slot
  import txb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_req,
  input  logic       set_abort,
  input  logic       wr,
  input  logic [1:0] wdata,
  input  logic       xmit_i,
  input  logic       sel_i,
  input  logic       scan_busy,
  input  logic       frame_ok,
  output logic       req_o,
  output logic       abort_o,
  output logic [1:0] code_o,
  output logic       asts_o,
  output logic       abort_now_o,
  output logic       fin_o
);
  assign abort_now_o = abort_o && req_o && !xmit_i && !sel_i && !scan_busy;
  assign fin_o       = xmit_i && frame_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_o   <= 1'b0;
      abort_o <= 1'b0;
      code_o  <= RC_NONE;
      asts_o  <= 1'b0;
    end else if (abort_now_o) begin
      req_o   <= 1'b0;
      abort_o <= 1'b0;
      code_o  <= RC_ABORTED;
      asts_o  <= 1'b1;
    end else if (fin_o) begin
      req_o   <= 1'b0;
      abort_o <= 1'b0;
      code_o  <= abort_o ? RC_ABORTED : RC_SENT;
      if (abort_o) asts_o <= 1'b1;
    end else begin
      if (set_req && code_o == RC_NONE) req_o <= 1'b1;
      if (set_abort && req_o) abort_o <= 1'b1;
      if (wr && wdata == RC_NONE) begin
        code_o <= RC_NONE;
        asts_o <= 1'b0;
      end
    end
  end

  AST_ABORT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now_o |=> code_o == RC_ABORTED && !req_o && !abort_o && asts_o); // R4
  AST_SCAN_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    scan_busy && req_o && !xmit_i |=> req_o); // R5
  AST_XMIT_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xmit_i && req_o && !frame_ok |=> req_o); // R6
  AST_FIN_ABORTED: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o && abort_o |=> code_o == RC_ABORTED && asts_o && !req_o); // R6
  AST_FIN_SENT: assert property (@(posedge clk) disable iff (!rst_n)
    fin_o && !abort_o |=> code_o == RC_SENT && !req_o); // R7
  AST_NO_CODE11: assert property (@(posedge clk) disable iff (!rst_n)
    code_o != 2'b11); // R7
  AST_NZ_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr && wdata != RC_NONE && !fin_o && !abort_now_o |=> $stable(code_o)); // R11
  AST_REQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    code_o != RC_NONE && !req_o |=> !req_o); // R11
endmodule

// File: rtl/txb_ctrl.sv
module txb_ctrl
  import txb_pkg::*;
#(
  parameter int NBUF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NBUF-1:0]   req_set,
  input  logic [NBUF-1:0]   abort_set,
  input  logic [NBUF-1:0]   code_wr,
  input  logic [2*NBUF-1:0] code_wdata,
  input  logic              abort_ie,
  input  logic              done_ie,
  input  logic              ev_sof,
  input  logic              ev_arb_lost,
  input  logic              ev_error,
  input  logic              ev_crc_delim,
  input  logic              ev_done,
  output logic [NBUF-1:0]   req_bits,
  output logic [NBUF-1:0]   abort_bits,
  output logic [2*NBUF-1:0] code_out,
  output logic [NBUF-1:0]   abort_sts,
  output logic [NBUF-1:0]   sel_oh,
  output logic [NBUF-1:0]   xmit_oh,
  output logic              scan_busy,
  output logic              irq_abort,
  output logic              irq_done
);
  logic [NBUF-1:0] abort_now_w, fin_w, cand, pick, is_aborted, is_sent;
  logic            scan_start, scan_finish, rescan_q, auto_start;

  genvar g;
  generate
    for (g = 0; g < NBUF; g++) begin : g_slot
      txb_slot u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_req    (req_set[g]),
        .set_abort  (abort_set[g]),
        .wr         (code_wr[g]),
        .wdata      (code_wdata[2*g +: 2]),
        .xmit_i     (xmit_oh[g]),
        .sel_i      (sel_oh[g]),
        .scan_busy  (scan_busy),
        .frame_ok   (ev_done),
        .req_o      (req_bits[g]),
        .abort_o    (abort_bits[g]),
        .code_o     (code_out[2*g +: 2]),
        .asts_o     (abort_sts[g]),
        .abort_now_o(abort_now_w[g]),
        .fin_o      (fin_w[g])
      );
      assign is_aborted[g] = code_out[2*g +: 2] == RC_ABORTED;
      assign is_sent[g]    = code_out[2*g +: 2] == RC_SENT;
    end
  endgenerate

  assign cand       = req_bits & ~abort_bits & ~xmit_oh;
  assign auto_start = !scan_busy && !(|sel_oh) && !(|xmit_oh) && !rescan_q && (|cand);
  assign scan_start = ev_error || (ev_crc_delim && rescan_q) || auto_start;

  txb_scan #(.NBUF(NBUF)) u_scan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (scan_start),
    .cand  (cand),
    .busy  (scan_busy),
    .finish(scan_finish),
    .pick  (pick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_oh   <= '0;
      xmit_oh  <= '0;
      rescan_q <= 1'b0;
    end else begin
      if (scan_finish) sel_oh <= pick;
      if (ev_done) begin
        xmit_oh <= '0;
      end else if (ev_error) begin
        xmit_oh  <= '0;
        sel_oh   <= '0;
        rescan_q <= 1'b0;
      end else if (ev_arb_lost) begin
        xmit_oh  <= '0;
        sel_oh   <= '0;
        rescan_q <= 1'b1;
      end else if (ev_crc_delim && rescan_q) begin
        sel_oh   <= '0;
        rescan_q <= 1'b0;
      end else if (ev_sof && |sel_oh) begin
        xmit_oh <= sel_oh;
        sel_oh  <= '0;
      end
    end
  end

  assign irq_abort = abort_ie && (|is_aborted);
  assign irq_done  = done_ie && (|is_sent);

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh)); // R2
  AST_XMIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(xmit_oh)); // R2
  AST_ARB_DROPS_XMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> xmit_oh == '0 && sel_oh == '0); // R8
  AST_WAIT_CRC_DELIM: assert property (@(posedge clk) disable iff (!rst_n)
    rescan_q && !scan_busy && !ev_crc_delim && !ev_error |=> !scan_busy); // R8
  AST_ERROR_RESCAN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_error |=> scan_busy && xmit_oh == '0); // R9
endmodule

// File: tb/tb_txb_ctrl.sv
module tb_txb_ctrl;
  localparam int NBUF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NBUF-1:0]   req_set = '0, abort_set = '0, code_wr = '0;
  logic [2*NBUF-1:0] code_wdata = '0;
  logic abort_ie = 1'b1, done_ie = 1'b1;
  logic ev_sof = 0, ev_arb_lost = 0, ev_error = 0, ev_crc_delim = 0, ev_done = 0;
  logic [NBUF-1:0]   req_bits, abort_bits, abort_sts, sel_oh, xmit_oh;
  logic [2*NBUF-1:0] code_out;
  logic scan_busy, irq_abort, irq_done;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    string      tag;
    int         idx;
    logic [1:0] code;
    logic       req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  txb_ctrl #(.NBUF(NBUF)) dut (
    .clk(clk), .rst_n(rst_n), .req_set(req_set), .abort_set(abort_set),
    .code_wr(code_wr), .code_wdata(code_wdata), .abort_ie(abort_ie), .done_ie(done_ie),
    .ev_sof(ev_sof), .ev_arb_lost(ev_arb_lost), .ev_error(ev_error),
    .ev_crc_delim(ev_crc_delim), .ev_done(ev_done), .req_bits(req_bits),
    .abort_bits(abort_bits), .code_out(code_out), .abort_sts(abort_sts),
    .sel_oh(sel_oh), .xmit_oh(xmit_oh), .scan_busy(scan_busy),
    .irq_abort(irq_abort), .irq_done(irq_done)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_buf(input string tag, input int idx, input logic [1:0] code, input logic req);
    exp_t e;
    e.tag = tag; e.idx = idx; e.code = code; e.req = req;
    sb.push_back(e);
  endtask

  // monitor side: compares every queued item against the outputs now
  task automatic monitor_drain();
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(code_out[2*e.idx +: 2] == e.code, e.tag, code_out[2*e.idx +: 2], e.code);
      check(req_bits[e.idx] == e.req, e.tag, req_bits[e.idx], e.req);
    end
  endtask

  task automatic wait_sel(input logic [NBUF-1:0] exp, input string tag);
    int n;
    n = 0;
    while (sel_oh != exp && n < 50) begin
      tick(1);
      n++;
    end
    check(sel_oh == exp, tag, sel_oh, exp);
  endtask

  task automatic pulse_ev(ref logic s);
    s = 1'b1; tick(1); s = 1'b0;
  endtask

  task automatic write_code(input int idx, input logic [1:0] v);
    code_wr[idx] = 1'b1;
    code_wdata[2*idx +: 2] = v;
    tick(1);
    code_wr = '0;
    code_wdata = '0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int busy_n;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check(req_bits == 0 && abort_bits == 0 && abort_sts == 0, "R1 bits", req_bits, 0);
    check(code_out == 0 && sel_oh == 0 && xmit_oh == 0, "R1 codes", code_out, 0);
    check(!scan_busy && !irq_abort && !irq_done, "R1 flags", {scan_busy, irq_abort, irq_done}, 0);

    // R2/R3: two requests at once, lowest index wins, scan length NBUF
    req_set = 4'b0110; tick(1); req_set = '0;
    busy_n = 0;
    for (int i = 0; i < 20 && sel_oh == 0; i++) begin
      tick(1);
      if (scan_busy) busy_n++;
    end
    check(sel_oh == 4'b0010, "R2 lowest index", sel_oh, 4'b0010);
    check(busy_n == NBUF, "R3 scan cycles", busy_n, NBUF);

    // R7: successful send of buffer 1
    pulse_ev(ev_sof);
    check(xmit_oh == 4'b0010, "R2 xmit follows sel", xmit_oh, 4'b0010);
    pulse_ev(ev_done);
    expect_buf("R7 sent code", 1, 2'b10, 1'b0);
    monitor_drain();
    check(irq_done, "R10 irq_done", irq_done, 1);
    wait_sel(4'b0100, "R3 auto rescan picks buffer 2");

    // R4: immediate abort of idle, unselected buffer 3
    req_set = 4'b1000; tick(1); req_set = '0;
    abort_set = 4'b1000; tick(1); abort_set = '0;
    tick(1);
    expect_buf("R4 immediate abort", 3, 2'b01, 1'b0);
    monitor_drain();
    check(abort_sts[3] && !abort_bits[3], "R4 status", {abort_sts[3], abort_bits[3]}, 2'b10);
    check(irq_abort, "R10 irq_abort", irq_abort, 1);

    // R11: non-zero code write ignored, request set blocked
    write_code(3, 2'b10);
    req_set = 4'b1000; tick(1); req_set = '0;
    tick(1);
    expect_buf("R11 ignored writes", 3, 2'b01, 1'b0);
    monitor_drain();
    // R10: write 00 clears codes and interrupts
    write_code(3, 2'b00);
    write_code(1, 2'b00);
    check(!irq_abort && !irq_done && abort_sts[3] == 0, "R10 clear by 00",
          {irq_abort, irq_done, abort_sts[3]}, 0);

    // R6: abort of selected buffer 2 is held until frame end
    abort_set = 4'b0100; tick(1); abort_set = '0;
    tick(2);
    expect_buf("R6 selected held", 2, 2'b00, 1'b1);
    monitor_drain();
    pulse_ev(ev_sof);
    tick(2);
    expect_buf("R6 transmitting held", 2, 2'b00, 1'b1);
    monitor_drain();
    pulse_ev(ev_done);
    expect_buf("R6 abort at frame end", 2, 2'b01, 1'b0);
    monitor_drain();
    check(abort_sts[2] && irq_abort, "R6 status", {abort_sts[2], irq_abort}, 2'b11);
    write_code(2, 2'b00);

    // R5: abort during a scan keeps the request until the scan ends
    req_set = 4'b0001; tick(1); req_set = '0;
    abort_set = 4'b0001; tick(1); abort_set = '0;
    check(scan_busy, "R5 scan running", scan_busy, 1);
    expect_buf("R5 request held in scan", 0, 2'b00, 1'b1);
    monitor_drain();
    tick(1);
    expect_buf("R5 request still held", 0, 2'b00, 1'b1);
    monitor_drain();
    tick(6);
    expect_buf("R5 abort after scan", 0, 2'b01, 1'b0);
    monitor_drain();
    check(sel_oh == 0, "R2 aborted buffer not picked", sel_oh, 0);
    write_code(0, 2'b00);

    // R8: arbitration loss, rescan only at the CRC delimiter
    req_set = 4'b0100; tick(1); req_set = '0;
    wait_sel(4'b0100, "R8 setup select");
    pulse_ev(ev_sof);
    pulse_ev(ev_arb_lost);
    check(xmit_oh == 0 && sel_oh == 0, "R8 xmit dropped", xmit_oh, 0);
    tick(3);
    check(!scan_busy, "R8 no early scan", scan_busy, 0);
    pulse_ev(ev_crc_delim);
    check(scan_busy, "R8 scan at crc delimiter", scan_busy, 1);
    wait_sel(4'b0100, "R8 reselect");

    // R9: error, rescan at once
    pulse_ev(ev_sof);
    pulse_ev(ev_error);
    check(xmit_oh == 0 && scan_busy, "R9 error rescan", {xmit_oh, scan_busy}, 1);
    wait_sel(4'b0100, "R9 reselect");

    // R7/R10: finish with interrupt gating
    done_ie = 1'b0;
    pulse_ev(ev_sof);
    pulse_ev(ev_done);
    expect_buf("R7 sent after retry", 2, 2'b10, 1'b0);
    monitor_drain();
    check(!irq_done, "R10 gated off", irq_done, 0);
    done_ie = 1'b1;
    tick(1);
    check(irq_done, "R10 gated on", irq_done, 1);
    write_code(2, 2'b00);
    check(!irq_done && code_out == 0, "R10 final clear", code_out, 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule